// File: doc/BRIEF.md
# Pulse-Driven Central Register File

This block keeps four 16-bit processor registers: a return-address register, a program counter, an accumulator and its lower (extension) half. A sequencer drives the block with one-cycle control pulses. Read pulses gate a register onto a shared read bus. Write pulses load a register from a shared write bus.

Most write pulses copy the bus unchanged. Two kinds of write pulse send the bus lines through a fixed per-bit map instead. The maps shift the value right by one. They copy the sign line into the top two bits. They also move the bit that falls out of the accumulator into the lower accumulator. Bits that a map does not name keep their old contents.

Every write pulse and every read pulse has an alias pulse that does the same thing. A clear pulse empties all four registers.

Register index used on every pulse vector: 0 = return address (Q), 1 = program counter (Z), 2 = lower accumulator (LP), 3 = accumulator (A). Bits are counted from 1 (LSB) to 16 (MSB).

Top module: `central_regfile`

## Requirements
- R1: When `clr_i` is high at a rising edge, all four registers hold 0 after that edge.
- R2: Bit k of `rd_main_i` or of `rd_alias_i` drives register k onto `rd_bus_o`, using the index above. The path has no register, so a read in the same cycle as a write returns the value held before the edge.
- R3: `rd_bus_o` is 0 when no read pulse is active. When several read pulses are active, `rd_bus_o` is the bitwise OR of the selected registers.
- R4: Bit 0, 1 or 3 of `wr_main_i` or `wr_alias_i` loads Q, Z or A with the whole `wr_bus_i` value at the next edge.
- R5: Bit 2 of `wr_main_i` or `wr_alias_i` loads LP through a map:
  - LP bits 16 and 15 take bus bit 1.
  - LP bit 14 becomes 0.
  - LP bits 13..1 take bus bits 14..2.
- R6: `wr_pair_i` loads A through a map:
  - A bits 16 and 15 take bus bit 16.
  - A bit 14 takes bus bit 15.
  - A bits 13..1 take bus bits 14..2.
- R7: During `wr_pair_i`, LP bit 14 takes bus bit 1. Every other LP bit keeps its previous value.
- R8: A register that no active write pulse targets keeps its value.
- R9: When two write pulses target the same register, the mapped write wins. `wr_pair_i` overrides a plain A write. The full LP map of R5 overrides the single LP bit written by `wr_pair_i`.
- R10: `clr_i` overrides every write pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| clr_i | input | 1 | General clear pulse |
| rd_main_i | input | 4 | Read pulses, one per register index |
| rd_alias_i | input | 4 | Alias read pulses, one per register index |
| wr_main_i | input | 4 | Write pulses (index 2 uses the LP map) |
| wr_alias_i | input | 4 | Alias write pulses (index 2 uses the LP map) |
| wr_pair_i | input | 1 | Combined A/LP shift write |
| wr_bus_i | input | 16 | Write bus |
| rd_bus_o | output | 16 | Read bus |

## Verification
The cases that matter are those where several functions fall in one cycle.

A read of a register in the cycle it is written must return the value held before the edge.

The pair write can coincide with a plain A write, with the LP map write, or with a clear. Random stimulus sets each pulse independently with a fairly high probability, so these overlaps occur often. Directed cycles also force each collision explicitly.

A bench model applies the priority order (clear, then mapped write, then plain write). Each following read is compared with that model. The alias pulses and the preserved LP bits are judged the same way.

// File: rtl/crf_pkg.sv
package crf_pkg;
   localparam int unsigned NREG = 4;
   typedef enum logic [1:0] {
      IX_RET  = 2'd0,
      IX_PC   = 2'd1,
      IX_LACC = 2'd2,
      IX_ACC  = 2'd3
   } reg_ix_e;
endpackage

// File: rtl/crf_word_reg.sv
module crf_word_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld_en,
   input  logic [W-1:0] ld_mask,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)
         q <= '0;
      else if (ld_en)
         q <= (q & ~ld_mask) | (ld_val & ld_mask);
   end
endmodule

// File: rtl/crf_write_map.sv
module crf_write_map #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] bus,
   output logic [W-1:0] acc_map,
   output logic [W-1:0] lacc_map,
   output logic [W-1:0] lacc_xfer
);
   localparam int unsigned LOW = W - 3;

   initial begin
      if (W < 4) $error("crf_write_map: W must be at least 4");
   end

   always_comb begin
      acc_map              = '0;
      acc_map[W-1]         = bus[W-1];
      acc_map[W-2]         = bus[W-1];
      acc_map[W-3]         = bus[W-2];
      acc_map[LOW-1:0]     = bus[W-3:1];

      lacc_map             = '0;
      lacc_map[W-1]        = bus[0];
      lacc_map[W-2]        = bus[0];
      lacc_map[W-3]        = 1'b0;
      lacc_map[LOW-1:0]    = bus[W-3:1];

      lacc_xfer            = '0;
      lacc_xfer[W-3]       = bus[0];
   end
endmodule

// File: rtl/crf_read_mux.sv
module crf_read_mux #(
   parameter int unsigned W    = 16,
   parameter int unsigned NREG = 4
) (
   input  logic [NREG-1:0]        sel,
   input  logic [NREG-1:0][W-1:0] regs,
   output logic [W-1:0]           bus
);
   logic [NREG:0][W-1:0] acc;
   assign acc[0] = '0;
   for (genvar i = 0; i < NREG; i++) begin : g_or
      assign acc[i+1] = acc[i] | (regs[i] & {W{sel[i]}});
   end
   assign bus = acc[NREG];
endmodule

// File: rtl/central_regfile.sv
module central_regfile
   import crf_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         clr_i,
   input  logic [3:0]   rd_main_i,
   input  logic [3:0]   rd_alias_i,
   input  logic [3:0]   wr_main_i,
   input  logic [3:0]   wr_alias_i,
   input  logic         wr_pair_i,
   input  logic [W-1:0] wr_bus_i,
   output logic [W-1:0] rd_bus_o
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] XFER_BIT = ALL_ONES'(1) << (W - 3);

   initial begin
      if (W < 4)    $error("central_regfile: W must be at least 4");
      if (NREG != 4) $error("central_regfile: exactly four registers expected");
   end

   logic [NREG-1:0]        wr_any;
   logic [NREG-1:0]        ld_en;
   logic [NREG-1:0][W-1:0] ld_mask;
   logic [NREG-1:0][W-1:0] ld_val;
   logic [NREG-1:0][W-1:0] reg_q;
   logic [W-1:0]           acc_map, lacc_map, lacc_xfer;

   crf_write_map #(.W(W)) map_i (
      .bus       (wr_bus_i),
      .acc_map   (acc_map),
      .lacc_map  (lacc_map),
      .lacc_xfer (lacc_xfer)
   );

   assign wr_any = wr_main_i | wr_alias_i;

   always_comb begin
      ld_en   = '0;
      ld_mask = '0;
      ld_val  = '0;
      ld_en[IX_RET]   = wr_any[IX_RET];
      ld_mask[IX_RET] = ALL_ONES;
      ld_val[IX_RET]  = wr_bus_i;
      ld_en[IX_PC]    = wr_any[IX_PC];
      ld_mask[IX_PC]  = ALL_ONES;
      ld_val[IX_PC]   = wr_bus_i;
      ld_en[IX_ACC]   = wr_any[IX_ACC] | wr_pair_i;
      ld_mask[IX_ACC] = ALL_ONES;
      ld_val[IX_ACC]  = wr_pair_i ? acc_map : wr_bus_i;
      ld_en[IX_LACC]  = wr_any[IX_LACC] | wr_pair_i;
      ld_mask[IX_LACC] = wr_any[IX_LACC] ? ALL_ONES : XFER_BIT;
      ld_val[IX_LACC]  = wr_any[IX_LACC] ? lacc_map : lacc_xfer;
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      crf_word_reg #(.W(W)) reg_i (
         .clk     (clk),
         .clr     (clr_i),
         .ld_en   (ld_en[i]),
         .ld_mask (ld_mask[i]),
         .ld_val  (ld_val[i]),
         .q       (reg_q[i])
      );
   end

   crf_read_mux #(.W(W), .NREG(NREG)) rmux_i (
      .sel  (rd_main_i | rd_alias_i),
      .regs (reg_q),
      .bus  (rd_bus_o)
   );
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
   parameter int unsigned W = 16
) (
   input logic                 clk,
   input logic                 clr_i,
   input logic [3:0]           rd_main_i,
   input logic [3:0]           rd_alias_i,
   input logic [3:0]           wr_main_i,
   input logic [3:0]           wr_alias_i,
   input logic                 wr_pair_i,
   input logic [W-1:0]         wr_bus_i,
   input logic [W-1:0]         rd_bus_o,
   input logic [3:0][W-1:0]    regs
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (clr_i) armed <= 1'b1;

   wire [3:0] wr_any = wr_main_i | wr_alias_i;

   // R1
   clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
      $past(clr_i) |-> (regs == '0));

   // R3
   idle_bus_chk: assert property (@(posedge clk) disable iff (!armed)
      ((rd_main_i | rd_alias_i) == 4'b0) |-> (rd_bus_o == '0));

   // R4
   ret_load_chk: assert property (@(posedge clk) disable iff (clr_i || !armed)
      wr_any[0] |=> (regs[0] == $past(wr_bus_i)));

   // R5
   lacc_map_chk: assert property (@(posedge clk) disable iff (clr_i || !armed)
      wr_any[2] |=> (regs[2][W-1] == $past(wr_bus_i[0]) && regs[2][W-2] == $past(wr_bus_i[0])
                     && regs[2][W-3] == 1'b0));

   // R6
   acc_sign_chk: assert property (@(posedge clk) disable iff (clr_i || !armed)
      wr_pair_i |=> (regs[3][W-1] == $past(wr_bus_i[W-1]) && regs[3][W-2] == $past(wr_bus_i[W-1])));

   // R7
   lacc_keep_chk: assert property (@(posedge clk) disable iff (clr_i || !armed)
      (wr_pair_i && !wr_any[2]) |=> (regs[2][W-3] == $past(wr_bus_i[0])
         && regs[2][W-4:0] == $past(regs[2][W-4:0]) && regs[2][W-1:W-2] == $past(regs[2][W-1:W-2])));

   // R8
   pc_hold_chk: assert property (@(posedge clk) disable iff (clr_i || !armed)
      !wr_any[1] |=> $stable(regs[1]));
endmodule

bind central_regfile crf_checker #(.W(W)) chk_i (
   .clk        (clk),
   .clr_i      (clr_i),
   .rd_main_i  (rd_main_i),
   .rd_alias_i (rd_alias_i),
   .wr_main_i  (wr_main_i),
   .wr_alias_i (wr_alias_i),
   .wr_pair_i  (wr_pair_i),
   .wr_bus_i   (wr_bus_i),
   .rd_bus_o   (rd_bus_o),
   .regs       (reg_q)
);

// File: tb/central_regfile_tb.sv
`timescale 1ns/1ps
module central_regfile_tb_top;
   logic        clk = 1'b0;
   logic        clr_i = 1'b0;
   logic [3:0]  rd_main_i = '0, rd_alias_i = '0, wr_main_i = '0, wr_alias_i = '0;
   logic        wr_pair_i = 1'b0;
   logic [15:0] wr_bus_i = '0;
   logic [15:0] rd_bus_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] m_reg [4];

   always #2.5 clk = ~clk;

   central_regfile dut_i (
      .clk(clk), .clr_i(clr_i), .rd_main_i(rd_main_i), .rd_alias_i(rd_alias_i),
      .wr_main_i(wr_main_i), .wr_alias_i(wr_alias_i), .wr_pair_i(wr_pair_i),
      .wr_bus_i(wr_bus_i), .rd_bus_o(rd_bus_o)
   );

   function automatic logic [15:0] map_acc(logic [15:0] b);
      return {b[15], b[15], b[14], b[13:1]};
   endfunction

   function automatic logic [15:0] map_lacc(logic [15:0] b);
      return {b[0], b[0], 1'b0, b[13:1]};
   endfunction

   function automatic logic [15:0] model_read(logic [3:0] sel);
      logic [15:0] r = '0;
      for (int i = 0; i < 4; i++) if (sel[i]) r |= m_reg[i];
      return r;
   endfunction

   task automatic model_step();
      logic [3:0] w = wr_main_i | wr_alias_i;
      if (clr_i) begin
         for (int i = 0; i < 4; i++) m_reg[i] = '0;
      end else begin
         if (w[0]) m_reg[0] = wr_bus_i;
         if (w[1]) m_reg[1] = wr_bus_i;
         if (wr_pair_i) m_reg[3] = map_acc(wr_bus_i);
         else if (w[3]) m_reg[3] = wr_bus_i;
         if (w[2]) m_reg[2] = map_lacc(wr_bus_i);
         else if (wr_pair_i) m_reg[2][13] = wr_bus_i[0];
      end
   endtask

   task automatic check(string tag, logic [15:0] exp);
      n_cmp++;
      if (rd_bus_o !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_bus=%h expected=%h", tag, rd_bus_o, exp);
      end
   endtask

   // Drive one cycle at the falling edge, compare the bus, then step the model.
   task automatic cycle(logic c, logic [3:0] rm, logic [3:0] ra, logic [3:0] wm,
                        logic [3:0] wa, logic wp, logic [15:0] b, string tag);
      clr_i = c; rd_main_i = rm; rd_alias_i = ra; wr_main_i = wm;
      wr_alias_i = wa; wr_pair_i = wp; wr_bus_i = b;
      #1;
      check(tag, model_read(rm | ra));
      model_step();
      @(negedge clk);
   endtask

   task automatic read_all(string tag);
      for (int i = 0; i < 4; i++) cycle(1'b0, 4'b1 << i, 4'b0, 4'b0, 4'b0, 1'b0, 16'h0, tag);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4; i++) m_reg[i] = 'x;
      @(negedge clk);
      clr_i = 1'b1; model_step(); @(negedge clk);
      read_all("R1 reset");
      cycle(0, 4'h0, 4'h0, 4'h0, 4'h0, 0, 16'h0, "R3 idle");
      // R4 alias writes, R2 alias reads
      cycle(0, 4'h0, 4'h0, 4'h0, 4'b0001, 0, 16'h1234, "R4 Q alias");
      cycle(0, 4'h0, 4'b0001, 4'b0010, 4'h0, 0, 16'hBEEF, "R2 read before write");
      cycle(0, 4'b0010, 4'h0, 4'h0, 4'h0, 0, 16'h0, "R4 Z");
      cycle(0, 4'b0011, 4'h0, 4'h0, 4'h0, 0, 16'h0, "R3 OR of two");
      // R6/R7 pair write, literal expectations
      cycle(0, 4'h0, 4'h0, 4'b1100, 4'h0, 0, 16'h0, "R4 zero A and LP");
      cycle(0, 4'h0, 4'h0, 4'h0, 4'h0, 1, 16'h8001, "R6 pair write");
      n_cmp++; if (m_reg[3] !== 16'hC000 || m_reg[2] !== 16'h2000) begin
         n_bad++; $display("FAIL R6 model: A=%h LP=%h expected=C000/2000", m_reg[3], m_reg[2]);
      end
      read_all("R6 R7 after pair");
      // R5 LP map via alias
      cycle(0, 4'h0, 4'h0, 4'h0, 4'b0100, 0, 16'h7FFF, "R5 LP map");
      read_all("R5 after LP map");
      cycle(0, 4'h0, 4'h0, 4'h0, 4'h0, 1, 16'h0000, "R7 keep other LP bits");
      read_all("R7 after pair");
      // R9 collisions
      cycle(0, 4'h0, 4'h0, 4'b1000, 4'h0, 1, 16'h4002, "R9 pair over A");
      cycle(0, 4'h0, 4'h0, 4'b0100, 4'h0, 1, 16'h2003, "R9 LP map over pair bit");
      read_all("R9 after collisions");
      // R10 clear beats writes
      cycle(1, 4'h0, 4'h0, 4'hF, 4'hF, 1, 16'hFFFF, "R10 clear wins");
      read_all("R10 after clear");
      // Random mix: R2 R3 R4 R5 R6 R7 R8 R9
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] rm = 4'($urandom) & 4'($urandom);
         logic [3:0] ra = 4'($urandom) & 4'($urandom);
         logic [3:0] wm = 4'($urandom) & 4'($urandom);
         logic [3:0] wa = 4'($urandom) & 4'($urandom) & 4'($urandom);
         logic       wp = ($urandom % 4) == 0;
         logic       c  = ($urandom % 64) == 0;
         cycle(c, rm, ra, wm, wa, wp, 16'($urandom), "R8 random mix");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule